// File: doc/BRIEF.md
# Spiking Tile Event Controller

This block sequences one compute tile that holds a synapse crossbar, a column of neuron cells and a routing table. It serves two directions. On the inbound side it accepts an address-event over a four-phase request/acknowledge handshake. It holds the event's axon row on the word-line address and sweeps a counter down across the target synapse columns. When every column has been selected it acknowledges and issues a one-cycle trigger for the pre-synaptic pulse. A non-zero time-multiplex count in the event makes the column sweep repeat, and each pass drives a different time-multiplex select value. This allows up to four physical column groups to feed one neuron.

On the outbound side a fire flag starts an upward scan of the neuron rows. The word-line address follows the counter until the sense input reports the firing row. The routing entry of that row is then captured and offered to the router over a second four-phase handshake. A reset request for the neuron is also raised. The router's acknowledge produces a one-cycle post-synaptic reset pulse. An inbound event that arrives together with a fire is served first. A scan that covers every row without a hit flags an error and returns to idle.

Top module: `tile_evt_ctrl`

## Requirements
- R1: After reset, in_ack, out_req, nrn_rst_req, pre_pulse, post_pulse and scan_err are 0, and wl_addr, col_sel and tm_sel are 0.
- R2: When in_req is seen high in idle, wl_addr equals the latched in_axon from the next cycle until the handshake ends, whatever the input fields do meanwhile.
- R3: During delivery, col_sel starts at in_fanout and falls by exactly one per cycle down to 0.
- R4: in_ack rises in the cycle after the final column-0 cycle, so delivery lasts (fanout+1)*(tm+1) cycles. pre_pulse is high for exactly that first in_ack cycle.
- R5: tm_sel starts at in_tm. After each column sweep that ends at 0 with tm_sel non-zero, tm_sel falls by one and col_sel reloads to the fanout value.
- R6: in_ack stays high while in_req is high and falls in the cycle after in_req falls.
- R7: A fire seen in idle with in_req low starts a scan: wl_addr is 0, 1, 2, ... on successive cycles while sense is 0.
- R8: A sense of 1 at row k raises out_req and nrn_rst_req in the next cycle. out_pkt then holds the rt_data presented at row k, and wl_addr stays at k.
- R9: out_req and nrn_rst_req stay high until out_ack. They fall in the next cycle, and post_pulse is high for that one cycle. The block returns to idle only once out_ack and fire are both 0.
- R10: If in_req and fire are both high in the same idle cycle, the inbound event is delivered first. The scan starts in the cycle after in_ack falls if fire is still high.
- R11: If no row reads sense 1 after all ROWS rows, scan_err pulses for one cycle, out_req is not raised, and the block is idle in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 1 | Inbound event request |
| in_axon | input | 8 | Inbound axon row field |
| in_fanout | input | 10 | Inbound highest target column |
| in_tm | input | 2 | Inbound extra column-group count |
| in_ack | output | 1 | Inbound acknowledge |
| wl_addr | output | 8 | Word-line row address (axon or scan row) |
| col_sel | output | 10 | Selected synapse column during delivery |
| tm_sel | output | 2 | Time-multiplex select |
| pre_pulse | output | 1 | One-cycle pre-synaptic pulse trigger |
| fire | input | 1 | Some neuron in the tile has fired |
| sense | input | 1 | Sense result of the neuron at wl_addr |
| rt_data | input | 21 | Routing entry of the row at wl_addr |
| out_req | output | 1 | Outbound event request to router |
| out_pkt | output | 21 | Outbound routing entry |
| out_ack | input | 1 | Router acknowledge |
| nrn_rst_req | output | 1 | Reset request for the identified neuron |
| post_pulse | output | 1 | One-cycle post-synaptic reset pulse trigger |
| scan_err | output | 1 | One-cycle flag: scan found no firing row |

## Verification
A table of inbound events drives the delivery path. The table covers zero fan-out (no sweep beyond column 0), small fan-outs with every time-multiplex count (this separates a missing reload from a missing tm decrement), and the widest fan-out (this exposes counter width or terminal-count errors). Outbound scans place the firing row at 0, mid-range and at the last row, so an off-by-one start or stop in the scan is visible. A scan with no firing row exercises the error exit. A simultaneous event and fire shows whether arbitration favours the inbound side.

// File: rtl/tile_evt_pkg.sv
package tile_evt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DELIV  = 3'd1,
    ST_INACK  = 3'd2,
    ST_SCAN   = 3'd3,
    ST_OUTREQ = 3'd4,
    ST_OUTREL = 3'd5
  } evt_st_e;

  // number of delivery cycles for one inbound event
  function automatic int unsigned sweep_cycles(int unsigned fanout, int unsigned tm);
    return (fanout + 1) * (tm + 1);
  endfunction

  // true when a scan counter value addresses the final row
  function automatic bit is_last_row(int unsigned cnt, int unsigned rows);
    return cnt == rows - 1;
  endfunction

endpackage

// File: rtl/evt_cnt.sv
module evt_cnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (dec)  q <= q - 1'b1;
    else if (inc)  q <= q + 1'b1;
  end
endmodule

// File: rtl/evt_ctrl_fsm.sv
module evt_ctrl_fsm
  import tile_evt_pkg::*;
#(
  parameter int ROWS  = 256,
  parameter int FO_W  = 10,
  parameter int TM_W  = 2,
  parameter int RT_W  = 21,
  parameter int ROW_W = $clog2(ROWS),
  parameter int CNT_W = (FO_W > ROW_W) ? FO_W : ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_req,
  input  logic [ROW_W-1:0] in_axon,
  input  logic [FO_W-1:0]  in_fanout,
  input  logic [TM_W-1:0]  in_tm,
  input  logic             fire,
  input  logic             sense,
  input  logic [RT_W-1:0]  rt_data,
  input  logic             out_ack,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [TM_W-1:0]  tm_q,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_dec,
  output logic             cnt_inc,
  output logic             tm_load,
  output logic [TM_W-1:0]  tm_val,
  output logic             tm_dec,
  output evt_st_e          st,
  output logic [ROW_W-1:0] axon_q,
  output logic [RT_W-1:0]  pkt_q,
  output logic             pre_pulse,
  output logic             post_pulse,
  output logic             scan_err
);
  evt_st_e         nxt;
  logic [FO_W-1:0] fo_q;
  logic            take_in, take_hit, pre_set, post_set, err_set;

  always_comb begin
    nxt      = st;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    cnt_inc  = 1'b0;
    tm_load  = 1'b0;
    tm_val   = '0;
    tm_dec   = 1'b0;
    take_in  = 1'b0;
    take_hit = 1'b0;
    pre_set  = 1'b0;
    post_set = 1'b0;
    err_set  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (in_req) begin
          take_in  = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(in_fanout);
          tm_load  = 1'b1;
          tm_val   = in_tm;
          nxt      = ST_DELIV;
        end else if (fire) begin
          cnt_load = 1'b1;
          nxt      = ST_SCAN;
        end
      end
      ST_DELIV: begin
        if (cnt_q != '0) begin
          cnt_dec = 1'b1;
        end else if (tm_q != '0) begin
          tm_dec   = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(fo_q);
        end else begin
          pre_set = 1'b1;
          nxt     = ST_INACK;
        end
      end
      ST_INACK: begin
        if (!in_req) nxt = ST_IDLE;
      end
      ST_SCAN: begin
        if (sense) begin
          take_hit = 1'b1;
          nxt      = ST_OUTREQ;
        end else if (is_last_row(int'(cnt_q), ROWS)) begin
          err_set = 1'b1;
          nxt     = ST_IDLE;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_OUTREQ: begin
        if (out_ack) begin
          post_set = 1'b1;
          nxt      = ST_OUTREL;
        end
      end
      ST_OUTREL: begin
        if (!out_ack && !fire) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      axon_q     <= '0;
      fo_q       <= '0;
      pkt_q      <= '0;
      pre_pulse  <= 1'b0;
      post_pulse <= 1'b0;
      scan_err   <= 1'b0;
    end else begin
      st         <= nxt;
      pre_pulse  <= pre_set;
      post_pulse <= post_set;
      scan_err   <= err_set;
      if (take_in) begin
        axon_q <= in_axon;
        fo_q   <= in_fanout;
      end
      if (take_hit) pkt_q <= rt_data;
    end
  end
endmodule

// File: rtl/tile_evt_ctrl.sv
module tile_evt_ctrl
  import tile_evt_pkg::*;
#(
  parameter int ROWS  = 256,
  parameter int FO_W  = 10,
  parameter int TM_W  = 2,
  parameter int RT_W  = 21,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_req,
  input  logic [ROW_W-1:0] in_axon,
  input  logic [FO_W-1:0]  in_fanout,
  input  logic [TM_W-1:0]  in_tm,
  output logic             in_ack,
  output logic [ROW_W-1:0] wl_addr,
  output logic [FO_W-1:0]  col_sel,
  output logic [TM_W-1:0]  tm_sel,
  output logic             pre_pulse,
  input  logic             fire,
  input  logic             sense,
  input  logic [RT_W-1:0]  rt_data,
  output logic             out_req,
  output logic [RT_W-1:0]  out_pkt,
  input  logic             out_ack,
  output logic             nrn_rst_req,
  output logic             post_pulse,
  output logic             scan_err
);
  localparam int CNT_W = (FO_W > ROW_W) ? FO_W : ROW_W;

  evt_st_e          st;
  logic [CNT_W-1:0] cnt_q, cnt_val;
  logic [TM_W-1:0]  tm_q, tm_val;
  logic             cnt_load, cnt_dec, cnt_inc, tm_load, tm_dec;
  logic [ROW_W-1:0] axon_q;
  logic [RT_W-1:0]  pkt_q;

  // named internal events for the checker
  logic dlv_active, scan_active, row_from_cnt;
  assign dlv_active   = (st == ST_DELIV);
  assign scan_active  = (st == ST_SCAN);
  assign row_from_cnt = (st == ST_SCAN) || (st == ST_OUTREQ) || (st == ST_OUTREL);

  evt_ctrl_fsm #(
    .ROWS(ROWS), .FO_W(FO_W), .TM_W(TM_W), .RT_W(RT_W),
    .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .in_req(in_req), .in_axon(in_axon), .in_fanout(in_fanout), .in_tm(in_tm),
    .fire(fire), .sense(sense), .rt_data(rt_data), .out_ack(out_ack),
    .cnt_q(cnt_q), .tm_q(tm_q),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .cnt_dec(cnt_dec), .cnt_inc(cnt_inc),
    .tm_load(tm_load), .tm_val(tm_val), .tm_dec(tm_dec),
    .st(st), .axon_q(axon_q), .pkt_q(pkt_q),
    .pre_pulse(pre_pulse), .post_pulse(post_pulse), .scan_err(scan_err)
  );

  // one counter serves both the column sweep and the row scan
  evt_cnt #(.W(CNT_W)) u_row_col_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .inc(cnt_inc), .q(cnt_q)
  );

  evt_cnt #(.W(TM_W)) u_tm_cnt (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val),
    .dec(tm_dec), .inc(1'b0), .q(tm_q)
  );

  assign in_ack      = (st == ST_INACK);
  assign out_req     = (st == ST_OUTREQ);
  assign nrn_rst_req = (st == ST_OUTREQ);
  assign out_pkt     = pkt_q;
  assign wl_addr     = row_from_cnt ? cnt_q[ROW_W-1:0] : axon_q;
  assign col_sel     = dlv_active ? cnt_q[FO_W-1:0] : '0;
  assign tm_sel      = tm_q;
endmodule

// File: rtl/tile_evt_ctrl_chk.sv
module tile_evt_ctrl_chk #(
  parameter int FO_W  = 10,
  parameter int RT_W  = 21,
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_req,
  input logic             in_ack,
  input logic             pre_pulse,
  input logic [FO_W-1:0]  col_sel,
  input logic [ROW_W-1:0] wl_addr,
  input logic             out_req,
  input logic             out_ack,
  input logic [RT_W-1:0]  out_pkt,
  input logic             post_pulse,
  input logic             scan_err,
  input logic             dlv_active,
  input logic             scan_active
);
  // R3
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_active && col_sel != '0 |=> col_sel == $past(col_sel) - 1'b1);

  // R4
  pre_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_pulse |-> in_ack && !$past(in_ack));

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && in_req |=> in_ack);

  // R2
  axon_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |-> $stable(wl_addr));

  // R9
  oreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && !out_ack |=> out_req);

  // R9
  post_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_pulse |-> !out_req && $past(out_req) && $past(out_ack));

  // R8
  pkt_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && $past(out_req) |-> $stable(out_pkt));

  // R11
  err_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_err |-> !out_req && !scan_active);
endmodule

bind tile_evt_ctrl tile_evt_ctrl_chk #(.FO_W(FO_W), .RT_W(RT_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
  .pre_pulse(pre_pulse), .col_sel(col_sel), .wl_addr(wl_addr),
  .out_req(out_req), .out_ack(out_ack), .out_pkt(out_pkt),
  .post_pulse(post_pulse), .scan_err(scan_err),
  .dlv_active(dlv_active), .scan_active(scan_active)
);

// File: tb/tile_evt_ctrl_tb.sv
module tile_evt_ctrl_tb;
  localparam int ROWS = 256;
  localparam int NV   = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_req = 1'b0;
  logic [7:0]  in_axon = '0;
  logic [9:0]  in_fanout = '0;
  logic [1:0]  in_tm = '0;
  logic        in_ack;
  logic [7:0]  wl_addr;
  logic [9:0]  col_sel;
  logic [1:0]  tm_sel;
  logic        pre_pulse;
  logic        fire = 1'b0;
  logic        sense;
  logic [20:0] rt_data;
  logic        out_req;
  logic [20:0] out_pkt;
  logic        out_ack = 1'b0;
  logic        nrn_rst_req;
  logic        post_pulse;
  logic        scan_err;

  logic        sense_en = 1'b0;
  logic [7:0]  sense_row = '0;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  function automatic logic [20:0] rt_model(logic [7:0] r);
    return {r[4:0] ^ 5'h15, r, ~r};
  endfunction

  assign sense   = sense_en && (wl_addr == sense_row);
  assign rt_data = rt_model(wl_addr);

  tile_evt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_axon(in_axon),
    .in_fanout(in_fanout), .in_tm(in_tm), .in_ack(in_ack), .wl_addr(wl_addr),
    .col_sel(col_sel), .tm_sel(tm_sel), .pre_pulse(pre_pulse), .fire(fire),
    .sense(sense), .rt_data(rt_data), .out_req(out_req), .out_pkt(out_pkt),
    .out_ack(out_ack), .nrn_rst_req(nrn_rst_req), .post_pulse(post_pulse),
    .scan_err(scan_err)
  );

  // stimulus table: {axon, fanout, tm}
  localparam logic [19:0] VEC [NV] = '{
    {8'd3,   10'd0,    2'd0},
    {8'd200, 10'd5,    2'd0},
    {8'd255, 10'd2,    2'd3},
    {8'd0,   10'd1,    2'd1},
    {8'd77,  10'd9,    2'd2},
    {8'd18,  10'd0,    2'd3},
    {8'd128, 10'd1023, 2'd0}
  };

  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; drives an event and follows it to the end of its handshake
  task automatic send_pkt(logic [7:0] ax, logic [9:0] fo, logic [1:0] tm);
    int bad_col = 0, bad_tm = 0, bad_wl = 0, early = 0;
    in_axon = ax; in_fanout = fo; in_tm = tm; in_req = 1'b1;
    @(negedge clk);
    // change the fields: latched copy must hold (R2)
    in_axon = ~ax; in_fanout = '0; in_tm = '0;
    for (int p = int'(tm); p >= 0; p--) begin
      for (int c = int'(fo); c >= 0; c--) begin
        if (col_sel != 10'(c)) bad_col++;
        if (tm_sel != 2'(p))   bad_tm++;
        if (wl_addr != ax)     bad_wl++;
        if (in_ack)            early++;
        @(negedge clk);
      end
    end
    check(bad_col == 0, "R3 column sweep", bad_col, 0);
    check(bad_tm == 0,  "R5 tm select sequence", bad_tm, 0);
    check(bad_wl == 0,  "R2 axon on word line", bad_wl, 0);
    check(early == 0 && in_ack, "R4 ack after last column", in_ack, 1);
    check(pre_pulse == 1'b1, "R4 pre pulse with ack", pre_pulse, 1);
    @(negedge clk);
    check(in_ack && !pre_pulse, "R6 ack held, pre pulse one cycle", {in_ack, pre_pulse}, 2);
    in_req = 1'b0;
    @(negedge clk);
    check(!in_ack, "R6 ack released", in_ack, 0);
  endtask

  // called at the negedge where fire is (or already was) high and the block is idle
  task automatic scan_hit(logic [7:0] k);
    int bad = 0;
    sense_row = k; sense_en = 1'b1; fire = 1'b1;
    for (int j = 0; j <= int'(k); j++) begin
      @(negedge clk);
      if (wl_addr != 8'(j) || out_req) bad++;
    end
    check(bad == 0, "R7 row scan order", bad, 0);
    @(negedge clk);
    check(out_req && nrn_rst_req, "R8 request raised", {out_req, nrn_rst_req}, 3);
    check(out_pkt == rt_model(k), "R8 routing entry", out_pkt, rt_model(k));
    check(wl_addr == k, "R8 row held", wl_addr, k);
    @(negedge clk);
    check(out_req && !post_pulse, "R9 request held until ack", {out_req, post_pulse}, 2);
    out_ack = 1'b1;
    @(negedge clk);
    check(!out_req && !nrn_rst_req && post_pulse, "R9 release and reset pulse",
          {out_req, nrn_rst_req, post_pulse}, 1);
    sense_en = 1'b0;
    @(negedge clk);
    check(!post_pulse, "R9 reset pulse one cycle", post_pulse, 0);
    out_ack = 1'b0;
    @(negedge clk);
    // fire still high: must not return to idle and rescan
    check(wl_addr == k && !out_req, "R9 waits for fire low", wl_addr, k);
    fire = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({in_ack, out_req, nrn_rst_req, pre_pulse, post_pulse, scan_err} == '0,
          "R1 control outputs", {in_ack, out_req, nrn_rst_req, pre_pulse, post_pulse, scan_err}, 0);
    check(wl_addr == 0 && col_sel == 0 && tm_sel == 0, "R1 addresses",
          {wl_addr, col_sel, tm_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      send_pkt(VEC[v][19:12], VEC[v][11:2], VEC[v][1:0]);
      @(negedge clk);
    end

    // scans: first, middle and last row
    scan_hit(8'd0);
    scan_hit(8'd97);
    scan_hit(8'd255);

    // R11 no firing row
    begin
      int bad = 0;
      sense_en = 1'b0; fire = 1'b1;
      for (int j = 0; j < ROWS; j++) begin
        @(negedge clk);
        if (wl_addr != 8'(j) || scan_err || out_req) bad++;
      end
      check(bad == 0, "R11 full scan without hit", bad, 0);
      @(negedge clk);
      check(scan_err && !out_req, "R11 error flag", {scan_err, out_req}, 2);
      fire = 1'b0;
      @(negedge clk);
      check(!scan_err && !out_req, "R11 error one cycle", scan_err, 0);
    end

    // R10 event and fire together: event first, then scan
    @(negedge clk);
    fire = 1'b1;
    sense_row = 8'd5; sense_en = 1'b1;
    send_pkt(8'd42, 10'd3, 2'd1);
    check(!out_req, "R10 no outbound during inbound", out_req, 0);
    scan_hit(8'd5);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule